// File: doc/BRIEF.md
# Command-Line CRC7 Generator and Checker

This block computes the 7-bit checksum used on the command line of SD and MMC cards. It sits next to the command shifter and takes one bit per card clock. A `bit_vld` strobe qualifies each bit. A `tok_start` pulse opens each token and selects its format: a short 48-bit token, or a long 136-bit token that carries card identification or card-specific data. The block counts the bits itself, so it knows which bits belong to the checked window, which ones are the CRC field, and which one is the closing end bit.

In transmit mode the block drives the whole token on `tx_bit`, one cycle behind the input. Payload and framing bits pass straight through. The block then substitutes the seven remainder bits, most significant first, and a final end bit of 1.

In receive mode the block compares the seven CRC bits that arrive after the payload with its own remainder. It then gives a single-cycle verdict, either `crc_ok` or `crc_fail`.

Top module: `cmd_crc7_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `crc_out` is 0 and `tx_vld`, `crc_ok` and `crc_fail` are 0.
- R2: A `tok_start` pulse clears the remainder, so `crc_out` reads 0 in the following cycle. It also latches `long_fmt` (1 selects a 136-bit token, 0 a 48-bit token) and `tx_mode` (1 transmit, 0 receive). A token in progress is abandoned and counting restarts at bit 0.
- R3: For a short token, the first 40 valid bits are checked, numbered from 0. They are divided as polynomial x^7+x^3+1, with the earliest bit as the highest-order term and seven zero bits appended. `crc_out` holds the 7-bit remainder from the cycle after bit 39 until the next `tok_start`.
- R4: For a long token, bits 0 to 7 (start, transmitter and six reserved bits) have no effect on the remainder. Only bits 8 to 127, which are 120 bits, are checked.
- R5: A cycle with `bit_vld` low has no effect: gaps between bits do not change the remainder, the stream or the verdict.
- R6: In transmit mode, `tx_vld` is high in the cycle after each of the token's 48 or 136 valid bits. For bits before the CRC field, `tx_bit` equals the input bit. For the next seven bits it carries the remainder, MSB first. For the last bit it is 1.
- R7: In receive mode, the cycle after the seventh CRC-field bit, `crc_ok` is high for exactly one cycle if all seven bits equal the remainder.
- R8: In that same cycle `crc_fail` is high instead if any of the seven bits differs. The two outputs are never high together.
- R9: Valid bits after the token's last bit are ignored until the next `tok_start`: `tx_vld` stays 0, `crc_out` is unchanged and no verdict is given.
- R10: In transmit mode, `crc_ok` and `crc_fail` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_start | input | 1 | Opens a token; latches format and direction |
| long_fmt | input | 1 | 1 = 136-bit token, 0 = 48-bit token (sampled on tok_start) |
| tx_mode | input | 1 | 1 = transmit, 0 = receive (sampled on tok_start) |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial token bit, earliest bit first |
| crc_out | output | 7 | Running or final remainder |
| tx_bit | output | 1 | Transmit stream bit |
| tx_vld | output | 1 | tx_bit is valid |
| crc_ok | output | 1 | Single-cycle pulse: received CRC matched |
| crc_fail | output | 1 | Single-cycle pulse: received CRC mismatched |

## Verification
A wrong remainder bit shows on `crc_out` in the cycle after the bit that corrupted it. In transmit mode it also shows in the CRC bits of `tx_bit`, at most seven bits later. A bit counter that is off by one shifts the checked window. That changes the remainder of known tokens and moves the verdict pulse away from the cycle after the seventh CRC bit, so both effects are visible within a single token. The bench uses tokens whose two long-format framing variants must give equal remainders. It also inserts gaps and sends bits past the end of the frame, so a skip or ignore path that leaks shows up at the ports within the same token.

// File: rtl/cmd_crc7_pkg.sv
package cmd_crc7_pkg;

  // Where the bit counter sits within a token
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SKIP,
    PH_COV,
    PH_CRC,
    PH_END
  } phase_e;

  // Per-token settings latched on tok_start
  typedef struct packed {
    logic long_fmt;
    logic tx_mode;
  } tok_cfg_t;

endpackage

// File: rtl/crc7_framer.sv
module crc7_framer
  import cmd_crc7_pkg::*;
#(
  parameter int CRC_W      = 7,
  parameter int SHORT_SKIP = 0,
  parameter int SHORT_COV  = 40,
  parameter int LONG_SKIP  = 8,
  parameter int LONG_COV   = 120,
  parameter int END_BITS   = 1,
  parameter int POS_W      = 8,
  parameter int K_W        = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tok_start,
  input  logic           long_fmt,
  input  logic           tx_mode,
  input  logic           bit_vld,
  output logic           step,
  output logic           tx_q,
  output phase_e         phase,
  output logic [K_W-1:0] crc_idx
);

  tok_cfg_t         cfg_q;
  logic [POS_W-1:0] pos_q;
  logic             active_q;

  logic [POS_W-1:0] skip_n;
  logic [POS_W-1:0] cov_end;
  logic [POS_W-1:0] crc_end;
  logic [POS_W-1:0] last_pos;
  logic [POS_W-1:0] idx_full;

  always_comb begin
    skip_n   = cfg_q.long_fmt ? POS_W'(LONG_SKIP) : POS_W'(SHORT_SKIP);
    cov_end  = skip_n + (cfg_q.long_fmt ? POS_W'(LONG_COV) : POS_W'(SHORT_COV));
    crc_end  = cov_end + POS_W'(CRC_W);
    last_pos = crc_end + POS_W'(END_BITS) - POS_W'(1);
    idx_full = pos_q - cov_end;
  end

  always_comb begin
    if (!active_q)            phase = PH_IDLE;
    else if (pos_q < skip_n)  phase = PH_SKIP;
    else if (pos_q < cov_end) phase = PH_COV;
    else if (pos_q < crc_end) phase = PH_CRC;
    else                      phase = PH_END;
  end

  assign crc_idx = idx_full[K_W-1:0];
  assign step    = bit_vld && active_q && !tok_start;
  assign tx_q    = cfg_q.tx_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (tok_start) begin
      cfg_q.long_fmt <= long_fmt;
      cfg_q.tx_mode  <= tx_mode;
      pos_q          <= '0;
      active_q       <= 1'b1;
    end else if (step) begin
      pos_q <= pos_q + POS_W'(1);
      if (pos_q == last_pos) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/crc7_lfsr.sv
module crc7_lfsr #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] nxt;
  logic         fb;

  assign fb     = din ^ crc_q[W-1];
  assign nxt[0] = fb;

  // One tap per polynomial term; the x^W term is the feedback itself
  for (genvar i = 1; i < W; i++) begin : g_tap
    if (POLY[i]) begin : g_xor
      assign nxt[i] = crc_q[i-1] ^ fb;
    end else begin : g_pass
      assign nxt[i] = crc_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (en)    crc_q <= nxt;
  end

  assign crc = crc_q;

endmodule

// File: rtl/crc7_tx_ser.sv
module crc7_tx_ser
  import cmd_crc7_pkg::*;
#(
  parameter int W   = 7,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           strobe,
  input  phase_e         phase,
  input  logic [K_W-1:0] crc_idx,
  input  logic           bit_in,
  input  logic [W-1:0]   crc,
  output logic           tx_bit,
  output logic           tx_vld
);

  logic [W-1:0] crc_sh;
  logic         sel_bit;

  assign crc_sh = crc << crc_idx;

  always_comb begin
    case (phase)
      PH_CRC:  sel_bit = crc_sh[W-1];
      PH_END:  sel_bit = 1'b1;
      default: sel_bit = bit_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_bit <= 1'b0;
      tx_vld <= 1'b0;
    end else begin
      tx_vld <= strobe;
      if (strobe) tx_bit <= sel_bit;
    end
  end

endmodule

// File: rtl/crc7_rx_cmp.sv
module crc7_rx_cmp
  import cmd_crc7_pkg::*;
#(
  parameter int W   = 7,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           strobe,
  input  phase_e         phase,
  input  logic [K_W-1:0] crc_idx,
  input  logic           bit_in,
  input  logic [W-1:0]   crc,
  output logic           crc_ok,
  output logic           crc_fail
);

  logic [W-1:0] crc_sh;
  logic         in_crc;
  logic         diff;
  logic         last;
  logic         mism_q;

  assign crc_sh = crc << crc_idx;
  assign in_crc = strobe && (phase == PH_CRC);
  assign diff   = bit_in ^ crc_sh[W-1];
  assign last   = (crc_idx == K_W'(W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mism_q   <= 1'b0;
      crc_ok   <= 1'b0;
      crc_fail <= 1'b0;
    end else begin
      crc_ok   <= 1'b0;
      crc_fail <= 1'b0;
      if (in_crc) begin
        mism_q <= mism_q | diff;
        if (last) begin
          crc_ok   <= !(mism_q | diff);
          crc_fail <= mism_q | diff;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_crc7_unit.sv
module cmd_crc7_unit
  import cmd_crc7_pkg::*;
#(
  parameter int               CRC_W      = 7,
  parameter logic [CRC_W-1:0] POLY       = 7'h09,
  parameter int               SHORT_SKIP = 0,
  parameter int               SHORT_COV  = 40,
  parameter int               LONG_SKIP  = 8,
  parameter int               LONG_COV   = 120,
  parameter int               END_BITS   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_start,
  input  logic             long_fmt,
  input  logic             tx_mode,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_out,
  output logic             tx_bit,
  output logic             tx_vld,
  output logic             crc_ok,
  output logic             crc_fail
);

  localparam int LONG_LEN = LONG_SKIP + LONG_COV + CRC_W + END_BITS;
  localparam int POS_W    = $clog2(LONG_LEN + 1);
  localparam int K_W      = $clog2(CRC_W);

  logic           step;
  logic           tx_q;
  phase_e         phase;
  logic [K_W-1:0] crc_idx;

  crc7_framer #(
    .CRC_W(CRC_W), .SHORT_SKIP(SHORT_SKIP), .SHORT_COV(SHORT_COV),
    .LONG_SKIP(LONG_SKIP), .LONG_COV(LONG_COV), .END_BITS(END_BITS),
    .POS_W(POS_W), .K_W(K_W)
  ) framer_i (
    .clk(clk), .rst(rst), .tok_start(tok_start), .long_fmt(long_fmt),
    .tx_mode(tx_mode), .bit_vld(bit_vld), .step(step), .tx_q(tx_q),
    .phase(phase), .crc_idx(crc_idx)
  );

  crc7_lfsr #(.W(CRC_W), .POLY(POLY)) lfsr_i (
    .clk(clk), .rst(rst), .clr(tok_start),
    .en(step && (phase == PH_COV)), .din(bit_in), .crc(crc_out)
  );

  crc7_tx_ser #(.W(CRC_W), .K_W(K_W)) tx_i (
    .clk(clk), .rst(rst), .clr(tok_start), .strobe(step && tx_q),
    .phase(phase), .crc_idx(crc_idx), .bit_in(bit_in), .crc(crc_out),
    .tx_bit(tx_bit), .tx_vld(tx_vld)
  );

  crc7_rx_cmp #(.W(CRC_W), .K_W(K_W)) rx_i (
    .clk(clk), .rst(rst), .clr(tok_start), .strobe(step && !tx_q),
    .phase(phase), .crc_idx(crc_idx), .bit_in(bit_in), .crc(crc_out),
    .crc_ok(crc_ok), .crc_fail(crc_fail)
  );

endmodule

// File: rtl/cmd_crc7_chk.sv
module cmd_crc7_chk #(
  parameter int CRC_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tok_start,
  input logic             bit_vld,
  input logic [CRC_W-1:0] crc_out,
  input logic             tx_vld,
  input logic             crc_ok,
  input logic             crc_fail
);

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    tok_start |=> (crc_out == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !tok_start) |=> $stable(crc_out));

  // R6
  tx_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> $past(bit_vld));

  // R7
  ok_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    crc_ok |=> !crc_ok);

  // R8
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(crc_ok && crc_fail));

  // R7
  verdict_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_ok || crc_fail) |-> $past(bit_vld));

endmodule

bind cmd_crc7_unit cmd_crc7_chk #(.CRC_W(CRC_W)) chk_i (
  .clk(clk), .rst(rst), .tok_start(tok_start), .bit_vld(bit_vld),
  .crc_out(crc_out), .tx_vld(tx_vld), .crc_ok(crc_ok), .crc_fail(crc_fail)
);

// File: tb/cmd_crc7_unit_tb_top.sv
module cmd_crc7_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tok_start = 1'b0;
  logic       long_fmt = 1'b0;
  logic       tx_mode = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [6:0] crc_out;
  logic       tx_bit, tx_vld, crc_ok, crc_fail;

  always #5 clk = ~clk;

  cmd_crc7_unit dut_i (
    .clk(clk), .rst(rst), .tok_start(tok_start), .long_fmt(long_fmt),
    .tx_mode(tx_mode), .bit_vld(bit_vld), .bit_in(bit_in),
    .crc_out(crc_out), .tx_bit(tx_bit), .tx_vld(tx_vld),
    .crc_ok(crc_ok), .crc_fail(crc_fail)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int           ok_cnt, fail_cnt, ok_at, fail_at, sent, tx_cnt;
  logic [135:0] tx_cap;

  // {payload 40, expected CRC 7}
  localparam logic [46:0] VEC [4] = '{
    {40'h40_0000_0000, 7'h4A},
    {40'h48_0000_01AA, 7'h43},
    {40'h77_0000_0000, 7'h32},
    {40'h51_DEAD_BEEF, 7'h00}   // 0: compute in bench
  };

  task automatic check(input bit cond, input string req,
                       input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Polynomial long division by x^7+x^3+1 of msg * x^7
  function automatic logic [6:0] crc_div(input logic [127:0] msg, input int n);
    logic [134:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i+7] = msg[i];
    for (int i = n + 6; i >= 7; i--)
      if (v[i]) v[i-:8] = v[i-:8] ^ 8'h89;
    return v[6:0];
  endfunction

  task automatic sample();
    if (tx_vld) begin
      tx_cap = {tx_cap[134:0], tx_bit};
      tx_cnt++;
    end
    if (crc_ok) begin ok_cnt++; ok_at = sent; end
    if (crc_fail) begin fail_cnt++; fail_at = sent; end
  endtask

  task automatic send_tok(input logic lf, input logic tx,
                          input logic [135:0] bits, input int n, input int gap);
    ok_cnt = 0; fail_cnt = 0; ok_at = -1; fail_at = -1; sent = 0;
    tx_cnt = 0; tx_cap = '0;
    @(negedge clk);
    long_fmt = lf; tx_mode = tx; tok_start = 1'b1; bit_vld = 1'b0;
    @(negedge clk);
    tok_start = 1'b0;
    check(crc_out == 7'h00, "R2 clear on start", {129'b0, crc_out}, 136'h0);
    for (int i = n - 1; i >= 0; i--) begin
      bit_vld = 1'b1; bit_in = bits[i];
      @(negedge clk);
      sent++;
      sample();
      bit_vld = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        sample();
      end
    end
    bit_vld = 1'b0;
    repeat (2) begin @(negedge clk); sample(); end
  endtask

  function automatic logic [135:0] short_tok(input logic [39:0] p, input logic [6:0] c);
    return {88'h0, p, c, 1'b1};
  endfunction

  function automatic logic [135:0] long_tok(input logic [7:0] f,
                                            input logic [119:0] p, input logic [6:0] c);
    return {f, p, c, 1'b1};
  endfunction

  localparam logic [119:0] LPAY = 120'h3F123456789ABCDEF00FEDCBA98765;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0]   c, lc, lc2;
    logic [135:0] t;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(crc_out == 0 && !tx_vld && !crc_ok && !crc_fail, "R1 in reset",
          {128'b0, crc_out, tx_vld, crc_ok}, 136'h0);
    rst = 1'b0;
    @(negedge clk);
    check(crc_out == 0 && !tx_vld && !crc_ok && !crc_fail, "R1 after reset",
          {128'b0, crc_out, tx_vld, crc_ok}, 136'h0);

    // Table walk: transmit then receive each short token
    for (int v = 0; v < 4; v++) begin
      c = (VEC[v][6:0] != 0) ? VEC[v][6:0] : crc_div({88'h0, VEC[v][46:7]}, 40);
      check(crc_div({88'h0, VEC[v][46:7]}, 40) == c, "R3 bench model",
            {129'b0, crc_div({88'h0, VEC[v][46:7]}, 40)}, {129'b0, c});
      t = short_tok(VEC[v][46:7], c);
      send_tok(1'b0, 1'b1, t, 48, 0);
      check(crc_out == c, "R3 short remainder", {129'b0, crc_out}, {129'b0, c});
      check(tx_cnt == 48 && tx_cap[47:0] == t[47:0], "R6 short tx stream",
            tx_cap, t);
      check(ok_cnt == 0 && fail_cnt == 0, "R10 no verdict in tx",
            136'(ok_cnt + fail_cnt), 136'h0);
      send_tok(1'b0, 1'b0, t, 48, 0);
      check(ok_cnt == 1 && fail_cnt == 0 && ok_at == 47, "R7 short match",
            136'(ok_at), 136'd47);
    end

    // R5: gaps between bits
    c = crc_div({88'h0, 40'h51_DEAD_BEEF}, 40);
    t = short_tok(40'h51_DEAD_BEEF, c);
    send_tok(1'b0, 1'b1, t, 48, 2);
    check(crc_out == c && tx_cnt == 48 && tx_cap[47:0] == t[47:0],
          "R5 gaps no effect", tx_cap, t);

    // R8: corrupted CRC bit, short token
    send_tok(1'b0, 1'b0, t ^ 136'h8, 48, 0);
    check(fail_cnt == 1 && ok_cnt == 0 && fail_at == 47, "R8 short mismatch",
          136'(fail_at), 136'd47);

    // R9: bits past end ignored
    for (int i = 0; i < 5; i++) begin
      bit_vld = 1'b1; bit_in = 1'b1;
      @(negedge clk);
      check(!tx_vld && !crc_ok && !crc_fail && crc_out == c, "R9 after end",
            {128'b0, crc_out, tx_vld}, {128'b0, c, 1'b0});
    end
    bit_vld = 1'b0;

    // R4: long tokens, framing bits excluded
    lc = crc_div(LPAY, 120);
    send_tok(1'b1, 1'b1, long_tok(8'h3F, LPAY, lc), 136, 0);
    lc2 = crc_out;
    check(lc2 == lc, "R4 long remainder", {129'b0, lc2}, {129'b0, lc});
    check(tx_cnt == 136 && tx_cap == long_tok(8'h3F, LPAY, lc), "R6 long tx stream",
          tx_cap, long_tok(8'h3F, LPAY, lc));
    send_tok(1'b1, 1'b0, long_tok(8'hC0, LPAY, lc), 136, 0);
    check(crc_out == lc2, "R4 framing ignored", {129'b0, crc_out}, {129'b0, lc2});
    check(ok_cnt == 1 && fail_cnt == 0 && ok_at == 135, "R7 long match",
          136'(ok_at), 136'd135);
    send_tok(1'b1, 1'b0, long_tok(8'h3F, LPAY, lc ^ 7'h40), 136, 0);
    check(fail_cnt == 1 && ok_cnt == 0, "R8 long mismatch",
          136'(fail_cnt), 136'd1);

    // R2: restart mid-token
    @(negedge clk);
    long_fmt = 1'b0; tx_mode = 1'b0; tok_start = 1'b1;
    @(negedge clk);
    tok_start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      bit_vld = 1'b1; bit_in = i[0];
      @(negedge clk);
    end
    bit_vld = 1'b0;
    c = crc_div({88'h0, 40'h40_0000_0000}, 40);
    send_tok(1'b0, 1'b0, short_tok(40'h40_0000_0000, c), 48, 0);
    check(ok_cnt == 1 && crc_out == 7'h4A, "R2 restart", {129'b0, crc_out}, 136'h4A);

    // R1: reset mid-token
    send_tok(1'b0, 1'b1, short_tok(40'h48_0000_01AA, 7'h43), 30, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(crc_out == 0 && !tx_vld && !crc_ok && !crc_fail, "R1 mid reset",
          {128'b0, crc_out, tx_vld}, 136'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule